// File: doc/BRIEF.md
# Programmed-I/O Sample Status Register

This block produces the 8-bit status byte that a host polls when it moves audio samples one byte at a time, without DMA, between itself and a stereo codec. For the playback direction it says whether the codec is waiting for another byte, which channel that byte belongs to, and which half of the sample word it is. For the capture direction it says the same about the byte waiting to be read. The block also holds a flag for a late sample, with separate capture-overrun and playback-underrun outputs, and a single sticky interrupt flag with its gated pin.

A sample-clock tick opens a new sample on both directions. Each host access to the playback or capture data register then moves that direction's byte pointer forward. The number of bytes in a sample follows the live mono/stereo and 8/16-bit format inputs. When the last byte of the sample has been moved, the ready bit drops until the next tick. The interrupt flag is set by a DMA-count underflow or a timer underflow. It stays set until the host writes any value to the status register.

Top module: `pioStatusReg`

## Requirements
- R1: Status byte layout from bit 7 down to bit 0 is: capture byte-half, capture channel, capture ready, late-sample flag, playback byte-half, playback channel, playback ready, interrupt flag. A channel bit is 1 for left or mono and 0 for right. A byte-half bit is 1 for the upper byte or any 8-bit format and 0 for the lower byte.
- R2: While reset is asserted and right after it, the status byte reads 8'hCC, the late-sample flags read 0, and the interrupt pin reads 0.
- R3: Within a sample, the byte order is: left lower, left upper, right lower, right upper for 16-bit stereo; lower, upper for 16-bit mono; left, right for 8-bit stereo; and a single byte for 8-bit mono. Byte k of the order is the one reported after k accesses.
- R4: A sample tick sets playback ready and points it at byte 0. Each playback data write while ready advances the pointer. The write of the last byte clears ready.
- R5: A sample tick sets capture ready and points it at byte 0. Each capture data read while ready advances the pointer. The read of the last byte clears ready.
- R6: Data accesses made while that direction's ready bit is 0 have no effect. While a ready bit is 0, its channel and byte-half bits both read 1.
- R7: On each sample tick, the capture-overrun output becomes the capture ready bit as it stood before that tick, and the playback-underrun output becomes the playback ready bit as it stood before that tick. The late-sample bit (bit 4) is the OR of the two, and all three hold until the next tick.
- R8: A DMA-count underflow pulse or a timer underflow pulse sets the interrupt flag. The flag stays set across ticks and data accesses.
- R9: A status-register write clears the interrupt flag. If an underflow pulse arrives in the same cycle as the write, the flag stays set.
- R10: The interrupt pin equals the interrupt flag when the interrupt enable is 1, and is 0 otherwise.
- R11: A sample tick takes priority over a data access in the same cycle. After such a cycle, the direction is ready at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | One-cycle pulse at each sample period |
| playWrStb | input | 1 | Host write to the playback data register |
| capRdStb | input | 1 | Host read of the capture data register |
| statWrStb | input | 1 | Host write to the status register |
| stereoEn | input | 1 | 1 = stereo, 0 = mono |
| wideEn | input | 1 | 1 = 16-bit samples, 0 = 8-bit |
| irqEn | input | 1 | Interrupt pin enable |
| dmaUnderflow | input | 1 | DMA current-count underflow pulse |
| timerUnderflow | input | 1 | Timer underflow pulse |
| statusByte | output | 8 | Status register contents |
| capOverrun | output | 1 | Last tick found a capture byte unread |
| playUnderrun | output | 1 | Last tick found playback bytes missing |
| irqPin | output | 1 | Gated interrupt output |

## Verification
The hardest state to reach from the ports is a mixed late sample, where one direction was fully serviced before the tick and the other was not. The other hard case is a tick that lands in the same cycle as a data access. The bench reaches the mixed case by finishing only the playback bytes of a sample before the next tick. It reaches the collision case by pulsing a tick together with a write and a read. It repeats the whole sequence for all four formats, and in each format it walks every byte index on both directions.

// File: rtl/pio_stat_pkg.sv
package pio_stat_pkg;
  localparam int IDX_W = 2;
  localparam int LANES = 2;
  localparam int PLAY = 0;
  localparam int CAP = 1;

  typedef struct packed {
    logic [LANES-1:0] arm;
    logic [LANES-1:0] adv;
    logic [IDX_W-1:0] lastIdx;
    logic             flagEval;
    logic             irqSet;
    logic             irqClr;
  } strobe_t;

  // returns {byteHalf, channel}; both 1 when nothing is pending
  function automatic logic [1:0] laneFields(input logic ready, input logic [IDX_W-1:0] idx,
                                            input logic stereo, input logic wide);
    logic upper, right;
    upper = wide ? idx[0] : 1'b1;
    right = stereo ? (wide ? idx[1] : idx[0]) : 1'b0;
    if (!ready) return 2'b11;
    return {upper, ~right};
  endfunction
endpackage

// File: rtl/pioStatCtrl.sv
module pioStatCtrl
  import pio_stat_pkg::*;
(
  input  logic             sampleTick,
  input  logic             playWrStb,
  input  logic             capRdStb,
  input  logic             statWrStb,
  input  logic             stereoEn,
  input  logic             wideEn,
  input  logic             dmaUnderflow,
  input  logic             timerUnderflow,
  input  logic [LANES-1:0] laneReady,
  output strobe_t          stb
);
  logic [LANES-1:0] access;

  assign access[PLAY] = playWrStb;
  assign access[CAP]  = capRdStb;

  always_comb begin
    stb.arm      = {LANES{sampleTick}};
    stb.adv      = access & laneReady & {LANES{~sampleTick}};
    stb.lastIdx  = IDX_W'({stereoEn, wideEn} == 2'b11 ? 3 :
                          (stereoEn | wideEn) ? 1 : 0);
    stb.flagEval = sampleTick;
    stb.irqSet   = dmaUnderflow | timerUnderflow;
    stb.irqClr   = statWrStb;
  end
endmodule

// File: rtl/pioLane.sv
module pioLane
  import pio_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             adv,
  input  logic [IDX_W-1:0] lastIdx,
  output logic             ready,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready <= 1'b0;
      idx   <= '0;
    end else if (arm) begin
      ready <= 1'b1;
      idx   <= '0;
    end else if (adv) begin
      if (idx >= lastIdx) begin
        ready <= 1'b0;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  a_r4_last_byte_clears: assert property (@(posedge clk) disable iff (!rstN)
    adv && !arm && idx == lastIdx |=> !ready);
  a_r11_tick_restarts: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> ready && idx == '0);
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !ready && !arm |=> !ready && $stable(idx));
endmodule

// File: rtl/pioStatData.sv
module pioStatData
  import pio_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             stereoEn,
  input  logic             wideEn,
  output logic [LANES-1:0] laneReady,
  output logic [7:0]       statusByte,
  output logic             capOverrun,
  output logic             playUnderrun,
  output logic             intFlag
);
  logic [IDX_W-1:0] laneIdx [LANES];
  logic [1:0]       laneFld [LANES];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    pioLane uLane (
      .clk(clk), .rstN(rstN), .arm(stb.arm[g]), .adv(stb.adv[g]),
      .lastIdx(stb.lastIdx), .ready(laneReady[g]), .idx(laneIdx[g])
    );
    assign laneFld[g] = laneFields(laneReady[g], laneIdx[g], stereoEn, wideEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capOverrun   <= 1'b0;
      playUnderrun <= 1'b0;
    end else if (stb.flagEval) begin
      capOverrun   <= laneReady[CAP];
      playUnderrun <= laneReady[PLAY];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           intFlag <= 1'b0;
    else if (stb.irqSet) intFlag <= 1'b1;
    else if (stb.irqClr) intFlag <= 1'b0;
  end

  assign statusByte = {laneFld[CAP], laneReady[CAP], capOverrun | playUnderrun,
                       laneFld[PLAY], laneReady[PLAY], intFlag};

  a_r7_underrun_seen: assert property (@(posedge clk) disable iff (!rstN)
    stb.flagEval && laneReady[PLAY] |=> playUnderrun);
  a_r7_overrun_seen: assert property (@(posedge clk) disable iff (!rstN)
    stb.flagEval && laneReady[CAP] |=> capOverrun);
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    intFlag && !stb.irqClr |=> intFlag);
  a_r9_irq_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.irqClr && !stb.irqSet |=> !intFlag);
endmodule

// File: rtl/pioStatusReg.sv
module pioStatusReg
  import pio_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       playWrStb,
  input  logic       capRdStb,
  input  logic       statWrStb,
  input  logic       stereoEn,
  input  logic       wideEn,
  input  logic       irqEn,
  input  logic       dmaUnderflow,
  input  logic       timerUnderflow,
  output logic [7:0] statusByte,
  output logic       capOverrun,
  output logic       playUnderrun,
  output logic       irqPin
);
  strobe_t          stb;
  logic [LANES-1:0] laneReady;
  logic             intFlag;

  pioStatCtrl uCtrl (
    .sampleTick(sampleTick), .playWrStb(playWrStb), .capRdStb(capRdStb),
    .statWrStb(statWrStb), .stereoEn(stereoEn), .wideEn(wideEn),
    .dmaUnderflow(dmaUnderflow), .timerUnderflow(timerUnderflow),
    .laneReady(laneReady), .stb(stb)
  );

  pioStatData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .stereoEn(stereoEn), .wideEn(wideEn),
    .laneReady(laneReady), .statusByte(statusByte), .capOverrun(capOverrun),
    .playUnderrun(playUnderrun), .intFlag(intFlag)
  );

  assign irqPin = intFlag & irqEn;
endmodule

// File: tb/sim_pioStatusReg.sv
module sim_pioStatusReg;
  logic clk = 1'b0, rstN = 1'b0;
  logic sampleTick = 0, playWrStb = 0, capRdStb = 0, statWrStb = 0;
  logic stereoEn = 0, wideEn = 0, irqEn = 0, dmaUnderflow = 0, timerUnderflow = 0;
  logic [7:0] statusByte;
  logic capOverrun, playUnderrun, irqPin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pioStatusReg u0 (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // expected {byteHalf, channel} for a lane (R1, R3, R6)
  function automatic logic [1:0] fld(input bit rdy, input int k, input bit s, input bit w);
    int right;
    if (!rdy) return 2'b11;
    right = s ? (w ? k / 2 : k) : 0;
    return {w ? 1'(k % 2) : 1'b1, 1'(right == 0)};
  endfunction

  function automatic logic [7:0] expByte(input bit cr, input int ck, input bit late,
                                         input bit pr, input int pk, input bit irq,
                                         input bit s, input bit w);
    return {fld(cr, ck, s, w), cr, late, fld(pr, pk, s, w), pr, irq};
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
    sampleTick = 0; playWrStb = 0; capRdStb = 0; statWrStb = 0;
    dmaUnderflow = 0; timerUnderflow = 0;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int f = 0; f < 4; f++) begin
      bit s, w;
      int n;
      s = f[1]; w = f[0]; n = (s ? 2 : 1) * (w ? 2 : 1);
      rstN = 0; stereoEn = s; wideEn = w;
      #3;
      chk("R2 in reset", statusByte, 8'hCC);
      @(negedge clk); rstN = 1; cyc();
      chk("R2 after reset", statusByte, 8'hCC);
      chk("R2 flags", {capOverrun, playUnderrun, irqPin}, 0);
      // ignored accesses before any tick (R6)
      playWrStb = 1; capRdStb = 1; cyc();
      chk("R6 idle access", statusByte, 8'hCC);
      sampleTick = 1; cyc();
      chk("R4 R5 tick arms", statusByte, expByte(1, 0, 0, 1, 0, 0, s, w));
      for (int k = 1; k <= n; k++) begin
        playWrStb = 1; cyc();
        chk("R3 R4 play step", statusByte, expByte(1, 0, 0, k < n, k % n, 0, s, w));
      end
      for (int k = 1; k <= n; k++) begin
        capRdStb = 1; cyc();
        chk("R3 R5 cap step", statusByte, expByte(k < n, k % n, 0, 0, 0, 0, s, w));
      end
      playWrStb = 1; capRdStb = 1; cyc();
      chk("R6 extra access ignored", statusByte, expByte(0, 0, 0, 0, 0, 0, s, w));
      sampleTick = 1; cyc();
      chk("R7 serviced no flag", {capOverrun, playUnderrun, statusByte[4]}, 0);
      sampleTick = 1; cyc();
      chk("R7 both late", {capOverrun, playUnderrun, statusByte[4]}, 3'b111);
      for (int k = 0; k < n; k++) begin playWrStb = 1; cyc(); end
      sampleTick = 1; cyc();
      chk("R7 capture only late", {capOverrun, playUnderrun, statusByte[4]}, 3'b101);
      for (int k = 0; k < n; k++) begin playWrStb = 1; capRdStb = 1; cyc(); end
      chk("R7 flag holds between ticks", {capOverrun, playUnderrun}, 2'b10);
      sampleTick = 1; cyc();
      chk("R7 cleared next tick", {capOverrun, playUnderrun, statusByte[4]}, 0);
      if (n > 1) begin
        playWrStb = 1; capRdStb = 1; cyc();
        sampleTick = 1; playWrStb = 1; capRdStb = 1; cyc();
        chk("R11 tick wins", statusByte, expByte(1, 0, 1, 1, 0, 0, s, w));
      end
    end
    // interrupt behaviour (R8 R9 R10)
    irqEn = 0; dmaUnderflow = 1; cyc();
    chk("R8 dma sets", statusByte[0], 1);
    chk("R10 pin gated off", irqPin, 0);
    sampleTick = 1; playWrStb = 1; cyc();
    chk("R8 sticky", statusByte[0], 1);
    irqEn = 1; #1;
    chk("R10 pin on", irqPin, 1);
    statWrStb = 1; cyc();
    chk("R9 status write clears", {statusByte[0], irqPin}, 0);
    timerUnderflow = 1; cyc();
    chk("R8 timer sets", {statusByte[0], irqPin}, 2'b11);
    statWrStb = 1; dmaUnderflow = 1; cyc();
    chk("R9 set beats clear", statusByte[0], 1);
    statWrStb = 1; cyc();
    chk("R9 cleared again", statusByte[0], 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule